// File: doc/BRIEF.md
# Supply-Driven Operating Mode Controller

This block picks the operating mode of a mixed-signal metering chip from the state of its supplies and clocks. It follows five modes: a reset mode, full operation, a battery-backed brownout mode with the measurement path off, a display-only mode where the segment display keeps running without the processor, and a sleep mode where only the oscillator and real-time clock stay powered. Transitions are driven by a main-supply-good flag, a battery-OK flag, firmware requests for sleep or display-only operation, and a pulse from the wake-up timer.

Independent of mode, a PLL-locked flag gates the converter and compute-engine enables. On its falling edge, a program-counter clear for the compute engine is raised in that same cycle. Rising and falling PLL edges each set an interrupt flag that stays set until firmware writes a one to its clear bit. The mode register and the flags are updated on the clock. The enables and the program-counter clear are decoded combinationally from the current mode and the live PLL flag.

Top module: `opmode_ctrl`

## Requirements
- R1: During and right after reset, the mode is RESET (`mode_oh` = 5'b00001), only `osc_en` and `rtc_en` are 1, and both interrupt flags are 0. The mode bit positions are: bit0 RESET, bit1 MISSION, bit2 BROWNOUT, bit3 DISPLAY, bit4 SLEEP.
- R2: In RESET, the next mode is MISSION if `main_ok` is 1, else BROWNOUT if `batt_ok` is 1, else RESET.
- R3: In MISSION, `main_ok` = 0 moves the controller to BROWNOUT on the next clock.
- R4: In BROWNOUT, DISPLAY or SLEEP, `main_ok` = 1 moves the controller to RESET on the next clock. This takes priority over every other input, and R2 then leads on to MISSION.
- R5: In BROWNOUT with `main_ok` = 0, a request (`req_sleep` or `req_disp`) leads to SLEEP when `batt_ok` is 1 (sleep wins over display), or to RESET when `batt_ok` is 0. With no request, the mode stays BROWNOUT.
- R6: DISPLAY and SLEEP are left only by `main_ok` = 1 or by `wake_tmo` = 1. A wake timeout without main power returns to BROWNOUT. Requests and `batt_ok` have no effect in these two modes.
- R7: Enables per mode. MISSION: cpu, disp, osc, rtc, plus adc and ce subject to R8. BROWNOUT: cpu, disp, osc, rtc. DISPLAY: disp, osc, rtc (cpu 0). SLEEP and RESET: osc and rtc only.
- R8: Whenever `pll_lock` is 0, `adc_en` and `ce_en` are 0, whatever the mode.
- R9: `ce_pc_clr` is 1 exactly in a cycle where `pll_lock` is 0 and was 1 in the previous cycle.
- R10: `irq_pll_rise` and `irq_pll_fall` are set on the clock after the matching edge of `pll_lock`. Each stays set until `irq_clr` bit0 (rise) or bit1 (fall) is 1. A set and a clear in the same cycle leave the flag set.
- R11: Exactly one bit of `mode_oh` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_ok | input | 1 | Main system supply is good |
| batt_ok | input | 1 | Battery is good |
| pll_lock | input | 1 | PLL is locked |
| req_sleep | input | 1 | Firmware request for sleep mode |
| req_disp | input | 1 | Firmware request for display-only mode |
| wake_tmo | input | 1 | Wake-up timer expiry pulse |
| irq_clr | input | 2 | Write-one-to-clear: bit0 rise flag, bit1 fall flag |
| mode_oh | output | 5 | One-hot mode indicator |
| adc_en | output | 1 | Converter enable |
| ce_en | output | 1 | Compute-engine enable |
| cpu_en | output | 1 | Processor enable |
| disp_en | output | 1 | Display enable |
| osc_en | output | 1 | Oscillator enable |
| rtc_en | output | 1 | Real-time clock enable |
| ce_pc_clr | output | 1 | Compute-engine program-counter clear |
| irq_pll_rise | output | 1 | PLL-rise interrupt flag |
| irq_pll_fall | output | 1 | PLL-fall interrupt flag |

## Verification
Two events can land in the same cycle: a loss of main power in MISSION and a PLL fall. The first changes the mode on the next clock. The second must drop `ce_en` and raise `ce_pc_clr` at once and set the fall flag a clock later. A directed step drops `main_ok` and `pll_lock` together. Random stimulus also meets this case, and sets and clears of a flag in one cycle, many times. A cycle-level reference model in the bench judges each such cycle by comparing the mode, the enables, the clear pulse and both flags.

// File: rtl/opmode_pkg.sv
package opmode_pkg;
  typedef enum logic [2:0] {
    MD_RESET   = 3'd0,
    MD_MISSION = 3'd1,
    MD_BROWN   = 3'd2,
    MD_DISP    = 3'd3,
    MD_SLEEP   = 3'd4
  } mode_e;

  localparam int NUM_MODES = 5;
  localparam int IRQ_W     = 2;  // bit0 PLL rise, bit1 PLL fall

  typedef struct packed {
    logic adc;
    logic ce;
    logic cpu;
    logic disp;
    logic osc;
    logic rtc;
  } en_t;

  // Block enables for a mode; the measurement path also needs a locked PLL.
  function automatic en_t mode_enables(mode_e m, logic pll);
    en_t e;
    e = '0;
    e.osc = 1'b1;
    e.rtc = 1'b1;
    case (m)
      MD_MISSION: begin
        e.cpu  = 1'b1;
        e.disp = 1'b1;
        e.adc  = pll;
        e.ce   = pll;
      end
      MD_BROWN: begin
        e.cpu  = 1'b1;
        e.disp = 1'b1;
      end
      MD_DISP: e.disp = 1'b1;
      default: ;
    endcase
    return e;
  endfunction

  // Mode sequencing; a returning main supply always wins.
  function automatic mode_e next_mode(mode_e m, logic main, logic batt,
                                      logic rs, logic rd, logic wk);
    mode_e n;
    n = m;
    case (m)
      MD_RESET:   n = main ? MD_MISSION : (batt ? MD_BROWN : MD_RESET);
      MD_MISSION: if (!main) n = MD_BROWN;
      MD_BROWN: begin
        if (main)            n = MD_RESET;
        else if (rs || rd)   n = !batt ? MD_RESET : (rs ? MD_SLEEP : MD_DISP);
      end
      MD_DISP, MD_SLEEP: begin
        if (main)            n = MD_RESET;
        else if (wk)         n = MD_BROWN;
      end
      default: n = MD_RESET;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/opmode_edge.sv
module opmode_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rose,
  output logic fell
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  assign rose = sig & ~prev_q;
  assign fell = ~sig & prev_q;
endmodule

// File: rtl/opmode_fsm.sv
module opmode_fsm
  import opmode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  main_ok,
  input  logic  batt_ok,
  input  logic  req_sleep,
  input  logic  req_disp,
  input  logic  wake_tmo,
  output mode_e mode
);
  mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MD_RESET;
    else        mode_q <= next_mode(mode_q, main_ok, batt_ok, req_sleep, req_disp, wake_tmo);
  end

  assign mode = mode_q;
endmodule

// File: rtl/opmode_irq.sv
module opmode_irq #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flag
);
  for (genvar g = 0; g < W; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)      q <= 1'b0;
      else if (set[g]) q <= 1'b1;
      else if (clr[g]) q <= 1'b0;
    end
    assign flag[g] = q;
  end
endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
  import opmode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 main_ok,
  input  logic                 batt_ok,
  input  logic                 pll_lock,
  input  logic                 req_sleep,
  input  logic                 req_disp,
  input  logic                 wake_tmo,
  input  logic [IRQ_W-1:0]     irq_clr,
  output logic [NUM_MODES-1:0] mode_oh,
  output logic                 adc_en,
  output logic                 ce_en,
  output logic                 cpu_en,
  output logic                 disp_en,
  output logic                 osc_en,
  output logic                 rtc_en,
  output logic                 ce_pc_clr,
  output logic                 irq_pll_rise,
  output logic                 irq_pll_fall
);
  mode_e            mode;
  en_t              en;
  logic             pll_rose;
  logic             pll_fell;
  logic [IRQ_W-1:0] irq_flag;

  opmode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .main_ok  (main_ok),
    .batt_ok  (batt_ok),
    .req_sleep(req_sleep),
    .req_disp (req_disp),
    .wake_tmo (wake_tmo),
    .mode     (mode)
  );

  opmode_edge u_pll_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  (pll_lock),
    .rose (pll_rose),
    .fell (pll_fell)
  );

  opmode_irq #(.W(IRQ_W)) u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .set  ({pll_fell, pll_rose}),
    .clr  (irq_clr),
    .flag (irq_flag)
  );

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_oh
    assign mode_oh[g] = (mode == mode_e'(g));
  end

  assign en        = mode_enables(mode, pll_lock);
  assign adc_en    = en.adc;
  assign ce_en     = en.ce;
  assign cpu_en    = en.cpu;
  assign disp_en   = en.disp;
  assign osc_en    = en.osc;
  assign rtc_en    = en.rtc;
  assign ce_pc_clr = pll_fell;

  assign irq_pll_rise = irq_flag[0];
  assign irq_pll_fall = irq_flag[1];
endmodule

// File: rtl/opmode_ctrl_chk.sv
module opmode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       main_ok,
  input logic       wake_tmo,
  input logic       pll_lock,
  input logic       pll_fell,
  input logic [4:0] mode_oh,
  input logic       adc_en,
  input logic       ce_en,
  input logic       cpu_en,
  input logic       disp_en,
  input logic       ce_pc_clr,
  input logic       irq_pll_fall
);
  // R11
  onehot_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_oh) == 1);

  // R8
  pll_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_lock |-> (!adc_en && !ce_en));

  // R3
  mission_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[1] && !main_ok) |=> mode_oh[2]);

  // R6
  lowpower_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_oh[3] || mode_oh[4]) && !main_ok && !wake_tmo) |=> $stable(mode_oh));

  // R9
  pc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_fell |-> (ce_pc_clr && !ce_en));

  // R10
  fall_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_fell |=> irq_pll_fall);

  // R7
  disp_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_oh[3] |-> (disp_en && !cpu_en));
endmodule

bind opmode_ctrl opmode_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .main_ok     (main_ok),
  .wake_tmo    (wake_tmo),
  .pll_lock    (pll_lock),
  .pll_fell    (pll_fell),
  .mode_oh     (mode_oh),
  .adc_en      (adc_en),
  .ce_en       (ce_en),
  .cpu_en      (cpu_en),
  .disp_en     (disp_en),
  .ce_pc_clr   (ce_pc_clr),
  .irq_pll_fall(irq_pll_fall)
);

// File: tb/tb_opmode_ctrl.sv
`timescale 1ns/1ps
module tb_opmode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_ok = 1'b0, batt_ok = 1'b0, pll_lock = 1'b0;
  logic       req_sleep = 1'b0, req_disp = 1'b0, wake_tmo = 1'b0;
  logic [1:0] irq_clr = 2'b00;
  logic [4:0] mode_oh;
  logic       adc_en, ce_en, cpu_en, disp_en, osc_en, rtc_en, ce_pc_clr;
  logic       irq_pll_rise, irq_pll_fall;

  int total = 0, bad = 0;
  bit done = 0;

  // Model state: 0 RESET, 1 MISSION, 2 BROWNOUT, 3 DISPLAY, 4 SLEEP
  int       m_mode = 0;
  bit       m_prev = 0;
  bit [1:0] m_irq  = 2'b00;

  always #4 clk = ~clk;  // 125 MHz

  opmode_ctrl dut (.*);

  function automatic int f_next(int m, bit mn, bit bt, bit rs, bit rd, bit wk);
    if (m == 0) return mn ? 1 : (bt ? 2 : 0);
    if (m == 1) return mn ? 1 : 2;
    if (mn) return 0;
    if (m == 2) begin
      if (!(rs || rd)) return 2;
      if (!bt) return 0;
      return rs ? 4 : 3;
    end
    return wk ? 2 : m;
  endfunction

  // {adc, ce, cpu, disp, osc, rtc}
  function automatic bit [5:0] f_en(int m, bit pll);
    case (m)
      1:       return {pll, pll, 4'b1111};
      2:       return 6'b001111;
      3:       return 6'b000111;
      default: return 6'b000011;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit mn, bit bt, bit pll, bit rs, bit rd, bit wk, bit [1:0] clr);
    bit fell, rose;
    @(negedge clk);
    main_ok = mn; batt_ok = bt; pll_lock = pll;
    req_sleep = rs; req_disp = rd; wake_tmo = wk; irq_clr = clr;
    #1;
    fell = m_prev && !pll;
    rose = !m_prev && pll;
    check(mode_oh == 5'(1 << m_mode), "R2/R3/R4/R5/R6/R11 mode", 8'(mode_oh), 8'(1 << m_mode));
    check({adc_en, ce_en, cpu_en, disp_en, osc_en, rtc_en} == f_en(m_mode, pll),
          "R7/R8 enables", 8'({adc_en, ce_en, cpu_en, disp_en, osc_en, rtc_en}),
          8'(f_en(m_mode, pll)));
    check(ce_pc_clr == fell, "R9 pc_clr", 8'(ce_pc_clr), 8'(fell));
    check({irq_pll_fall, irq_pll_rise} == m_irq, "R10 irq", 8'({irq_pll_fall, irq_pll_rise}),
          8'(m_irq));
    m_mode = f_next(m_mode, mn, bt, rs, rd, wk);
    m_irq  = (m_irq & ~clr) | {fell, rose};
    m_prev = pll;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(mode_oh == 5'b00001, "R1 mode", 8'(mode_oh), 8'b1);
    check({adc_en, ce_en, cpu_en, disp_en, osc_en, rtc_en} == 6'b000011, "R1 enables",
          8'({adc_en, ce_en, cpu_en, disp_en, osc_en, rtc_en}), 8'b11);
    check({irq_pll_fall, irq_pll_rise, ce_pc_clr} == 3'b000, "R1 flags",
          8'({irq_pll_fall, irq_pll_rise, ce_pc_clr}), 8'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: power up to MISSION, PLL locks (R10 rise)
    step(1, 1, 0, 0, 0, 0, 2'b00);
    step(1, 1, 1, 0, 0, 0, 2'b00);
    step(1, 1, 1, 0, 0, 0, 2'b00);
    // R10: clear of rise flag
    step(1, 1, 1, 0, 0, 0, 2'b01);
    // R3 + R9: main drop and PLL fall in the same cycle
    step(0, 1, 0, 0, 0, 0, 2'b00);
    step(0, 1, 0, 0, 0, 0, 2'b10);
    // R10: PLL rise with clear of rise in the same cycle, set wins
    step(0, 1, 1, 0, 0, 0, 2'b01);
    step(0, 1, 1, 0, 0, 0, 2'b00);
    // R5: both requests, sleep wins
    step(0, 1, 1, 1, 1, 0, 2'b00);
    // R6: requests ignored in SLEEP, then wake to BROWNOUT
    step(0, 0, 1, 0, 1, 0, 2'b00);
    step(0, 1, 1, 0, 0, 1, 2'b00);
    // R5: display request then R6 and R4 with main return beating wake
    step(0, 1, 1, 0, 1, 0, 2'b00);
    step(0, 1, 1, 1, 0, 0, 2'b00);
    step(1, 1, 1, 0, 0, 1, 2'b00);
    step(1, 1, 1, 0, 0, 0, 2'b00);
    step(0, 1, 1, 0, 0, 0, 2'b00);
    // R5: request without battery goes to RESET
    step(0, 0, 1, 1, 0, 0, 2'b00);
    step(0, 0, 1, 0, 0, 0, 2'b00);
    // Constrained random mix
    void'($urandom(32'd2024));
    begin
      bit mn = 0, bt = 1, pl = 0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(15) == 0) mn = !mn;
        if ($urandom_range(7) == 0)  pl = !pl;
        bt = ($urandom_range(3) != 0);
        step(mn, bt, pl, $urandom_range(7) == 0, $urandom_range(7) == 0,
             $urandom_range(9) == 0, ($urandom_range(3) == 0) ? 2'($urandom) : 2'b00);
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule